// File: doc/BRIEF.md
# PHY Loopback Test-Mode Controller

This block holds the loopback controls of an Ethernet PHY's management register set and steers the MII nibble paths to match them. A control register carries a general loopback enable, and a status register mirrors it. A loopback-and-bypass register holds finer test settings: a three-bit loop-path selector, a digital-loopback flag and two analog loopback enables, one for 100 Mb/s and one for 10 Mb/s.

The general loopback mode and the finer test modes exclude each other. Any write to the control register clears the selector and the digital flag, whatever value is written to the enable. While loopback is active, the selector and the digital flag cannot be written, and the two analog enables read as set. With loopback active, transmit nibbles come back on the MII receive outputs after one register stage, and the media transmit outputs stay quiet.

Without loopback, the receive outputs carry line data. At 10 Mb/s there is one exception: while the MAC transmits, its own nibbles are echoed to the receive outputs, and they also go out on the line. A management frame decoder drives the register port, which has a write strobe and reads that return data in the same cycle. The three-bit selector takes its reset value from a fiber-enable strap.

Top module: `phy_lpbk_ctrl`

## Requirements
- R1: On reset, the loopback enable is 0, the digital flag is 0 and both analog enables are 0. The selector (bits 9:7 of the loopback-and-bypass register) resets to 011 when the fiber strap is high, and to 000 when it is low.
- R2: Writing the control register sets the loopback enable from bit 14. Bit 14 reads back the enable, and all other control bits read 0. Bit 3 of the status register reads 1 exactly while loopback is enabled, and all other status bits read 0.
- R3: Any write to the control register forces the selector to 000 and the digital flag (bit 6) to 0. This holds whether bit 14 is written with 0 or with 1.
- R4: The loopback-and-bypass register has the selector at bits 9:7, the digital flag at bit 6, the 100 Mb/s analog enable at bit 5 and the 10 Mb/s analog enable at bit 4. With loopback off, it reads back what was written, and all other bits read 0. Reads return data combinationally in the same cycle as the address.
- R5: While loopback is enabled, rx_dv_o and rxd_o equal the tx_en_i and txd_i of the previous cycle, at either speed.
- R6: While loopback is enabled, media_tx_en_o and media_txd_o are 0 in the following cycle.
- R7: While loopback is enabled, bits 5 and 4 of the loopback-and-bypass register read 1. When loopback is disabled, they read their stored values again.
- R8: While loopback is enabled, writes to the loopback-and-bypass register leave the selector and the digital flag unchanged at 000 and 0. The stored analog enables are still updated.
- R9: At 10 Mb/s (speed100_i low) with loopback off, a cycle with tx_en_i high gives rx and media outputs equal to that cycle's transmit inputs, one cycle later. A cycle with tx_en_i low gives rx outputs equal to the line inputs, one cycle later.
- R10: At 100 Mb/s with loopback off, the rx outputs follow the line inputs and the media outputs follow the transmit inputs, each one cycle later.
- R11: Writes to the status register or to any unmapped address change no register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_fiber_i | input | 1 | Fiber-enable strap, sampled during reset |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| tx_en_i | input | 1 | MII transmit enable |
| txd_i | input | 4 | MII transmit nibble |
| line_rx_dv_i | input | 1 | Data valid from the line receive path |
| line_rxd_i | input | 4 | Nibble from the line receive path |
| rx_dv_o | output | 1 | MII receive data valid |
| rxd_o | output | 4 | MII receive nibble |
| media_tx_en_o | output | 1 | Transmit enable toward the media |
| media_txd_o | output | 4 | Transmit nibble toward the media |

## Verification
The bench builds the block with its default parameters: 5-bit addresses, 16-bit data, 4-bit nibbles, the control register at 0, the status register at 16 and the loopback-and-bypass register at 23.

At these values the bench pulses reset with the fiber strap both high and low, so both selector defaults are checked. Writes of 0 and of 1 to the loopback enable are each checked for clearing the test fields. Writes to the locked fields during loopback and the readback of the analog enables are checked as well. The nibble paths are driven at both speeds, with loopback on and off, and with the transmit enable both high and low.

// File: rtl/phy_lpbk_pkg.sv
// Package: shared bit positions, selector codes and the test-field record
// for the loopback controller.
package phy_lpbk_pkg;

    // Bit positions inside the management registers
    localparam int CTRL_LPBK_BIT = 14;
    localparam int STAT_LPBK_BIT = 3;
    localparam int LBR_SEL_LSB   = 7;
    localparam int LBR_SEL_W     = 3;
    localparam int LBR_DIG_BIT   = 6;
    localparam int LBR_A100_BIT  = 5;
    localparam int LBR_A10_BIT   = 4;

    // Selector codes
    localparam logic [LBR_SEL_W-1:0] SEL_NORMAL = 3'b000;
    localparam logic [LBR_SEL_W-1:0] SEL_FIBER  = 3'b011;

    // Stored contents of the loopback-and-bypass register
    typedef struct packed {
        logic [LBR_SEL_W-1:0] sel;
        logic                 dig;
        logic                 ana100;
        logic                 ana10;
    } lbr_fields_t;

endpackage

// File: rtl/phy_lpbk_regs.sv
// Module: phy_lpbk_regs
// Holds the loopback enable and the loopback-and-bypass fields. It applies
// the rule that the general mode and the finer modes exclude each other,
// and it serves combinational reads.
// Assumes: DATA_W >= 16 and that the three addresses are distinct.
module phy_lpbk_regs
    import phy_lpbk_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'd0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'd16,
    parameter logic [ADDR_W-1:0] LBR_ADDR  = 5'd23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_fiber_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              lpbk_o,
    output lbr_fields_t       lbr_o
);

    logic        lpbk_q;
    lbr_fields_t lbr_q;
    logic        unused_wdata_bits;

    assign unused_wdata_bits = ^wdata_i;

    // Register updates: a control write clears the test fields, and loopback locks them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lpbk_q       <= 1'b0;
            lbr_q.sel    <= strap_fiber_i ? SEL_FIBER : SEL_NORMAL;
            lbr_q.dig    <= 1'b0;
            lbr_q.ana100 <= 1'b0;
            lbr_q.ana10  <= 1'b0;
        end else if (we_i) begin
            if (addr_i == CTRL_ADDR) begin
                lpbk_q    <= wdata_i[CTRL_LPBK_BIT];
                lbr_q.sel <= SEL_NORMAL;
                lbr_q.dig <= 1'b0;
            end else if (addr_i == LBR_ADDR) begin
                if (!lpbk_q) begin
                    lbr_q.sel <= wdata_i[LBR_SEL_LSB +: LBR_SEL_W];
                    lbr_q.dig <= wdata_i[LBR_DIG_BIT];
                end
                lbr_q.ana100 <= wdata_i[LBR_A100_BIT];
                lbr_q.ana10  <= wdata_i[LBR_A10_BIT];
            end
        end
    end

    // Read mux: analog enables read as set while loopback is active
    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_ADDR) begin
            rdata_o[CTRL_LPBK_BIT] = lpbk_q;
        end else if (addr_i == STAT_ADDR) begin
            rdata_o[STAT_LPBK_BIT] = lpbk_q;
        end else if (addr_i == LBR_ADDR) begin
            rdata_o[LBR_SEL_LSB +: LBR_SEL_W] = lbr_q.sel;
            rdata_o[LBR_DIG_BIT]              = lbr_q.dig;
            rdata_o[LBR_A100_BIT]             = lbr_q.ana100 | lpbk_q;
            rdata_o[LBR_A10_BIT]              = lbr_q.ana10  | lpbk_q;
        end
    end

    assign lpbk_o = lpbk_q;
    assign lbr_o  = lbr_q;

endmodule

// File: rtl/phy_lpbk_mux.sv
// Module: phy_lpbk_mux
// Registered steering of the MII nibbles. With loopback on, transmit data
// returns on the receive side and the media side is silent. At 10 Mb/s,
// transmit data is echoed to the receive side while the MAC transmits.
// Assumes: one register stage on every output is acceptable.
module phy_lpbk_mux #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lpbk_i,
    input  logic             speed100_i,
    input  logic             tx_en_i,
    input  logic [NIB_W-1:0] txd_i,
    input  logic             line_rx_dv_i,
    input  logic [NIB_W-1:0] line_rxd_i,
    output logic             rx_dv_o,
    output logic [NIB_W-1:0] rxd_o,
    output logic             media_tx_en_o,
    output logic [NIB_W-1:0] media_txd_o
);

    logic echo10;

    // A 10 Mb/s transmission is echoed to the receive side
    always_comb echo10 = !speed100_i && tx_en_i;

    // Output stage: pick the receive source and gate the media side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_dv_o       <= 1'b0;
            rxd_o         <= '0;
            media_tx_en_o <= 1'b0;
            media_txd_o   <= '0;
        end else if (lpbk_i) begin
            rx_dv_o       <= tx_en_i;
            rxd_o         <= txd_i;
            media_tx_en_o <= 1'b0;
            media_txd_o   <= '0;
        end else begin
            media_tx_en_o <= tx_en_i;
            media_txd_o   <= txd_i;
            if (echo10) begin
                rx_dv_o <= tx_en_i;
                rxd_o   <= txd_i;
            end else begin
                rx_dv_o <= line_rx_dv_i;
                rxd_o   <= line_rxd_i;
            end
        end
    end

endmodule

// File: rtl/phy_lpbk_ctrl.sv
// Module: phy_lpbk_ctrl (top)
// Loopback test-mode controller. It joins the register file to the MII
// steering stage.
// Assumes: a management frame decoder drives the register port.
module phy_lpbk_ctrl
    import phy_lpbk_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int NIB_W  = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'd0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'd16,
    parameter logic [ADDR_W-1:0] LBR_ADDR  = 5'd23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_fiber_i,
    input  logic              speed100_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              tx_en_i,
    input  logic [NIB_W-1:0]  txd_i,
    input  logic              line_rx_dv_i,
    input  logic [NIB_W-1:0]  line_rxd_i,
    output logic              rx_dv_o,
    output logic [NIB_W-1:0]  rxd_o,
    output logic              media_tx_en_o,
    output logic [NIB_W-1:0]  media_txd_o
);

    logic        lpbk_en;
    lbr_fields_t lbr_cur;

    phy_lpbk_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR), .LBR_ADDR(LBR_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_fiber_i(strap_fiber_i),
        .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o), .lpbk_o(lpbk_en), .lbr_o(lbr_cur)
    );

    phy_lpbk_mux #(.NIB_W(NIB_W)) u_mux (
        .clk(clk), .rst_n(rst_n), .lpbk_i(lpbk_en), .speed100_i(speed100_i),
        .tx_en_i(tx_en_i), .txd_i(txd_i),
        .line_rx_dv_i(line_rx_dv_i), .line_rxd_i(line_rxd_i),
        .rx_dv_o(rx_dv_o), .rxd_o(rxd_o),
        .media_tx_en_o(media_tx_en_o), .media_txd_o(media_txd_o)
    );

endmodule

// File: rtl/phy_lpbk_chk.sv
// Module: phy_lpbk_chk
// Assertion checker for phy_lpbk_ctrl, attached with the bind at the end of
// this file.
// Assumes: it sees the enable and the stored test fields through the top's
// internal nets.
module phy_lpbk_chk
    import phy_lpbk_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int NIB_W  = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'd0,
    parameter logic [ADDR_W-1:0] LBR_ADDR  = 5'd23
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              lpbk,
    input lbr_fields_t       lbr,
    input logic              tx_en,
    input logic [NIB_W-1:0]  txd,
    input logic              rx_dv,
    input logic [NIB_W-1:0]  rxd,
    input logic              m_tx_en,
    input logic [NIB_W-1:0]  m_txd
);

    // R2
    lpbk_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == CTRL_ADDR) |=> (lpbk == $past(wdata[CTRL_LPBK_BIT])));

    // R3
    ctrl_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == CTRL_ADDR) |=> (lbr.sel == SEL_NORMAL && !lbr.dig));

    // R8
    fields_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk && we && addr == LBR_ADDR) |=> (lbr.sel == SEL_NORMAL && !lbr.dig));

    // R5
    rx_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk |=> (rx_dv == $past(tx_en) && rxd == $past(txd)));

    // R6
    media_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk |=> (!m_tx_en && m_txd == '0));

endmodule

bind phy_lpbk_ctrl phy_lpbk_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NIB_W(NIB_W),
    .CTRL_ADDR(CTRL_ADDR), .LBR_ADDR(LBR_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .we(reg_we_i), .addr(reg_addr_i),
    .wdata(reg_wdata_i), .lpbk(lpbk_en), .lbr(lbr_cur),
    .tx_en(tx_en_i), .txd(txd_i), .rx_dv(rx_dv_o), .rxd(rxd_o),
    .m_tx_en(media_tx_en_o), .m_txd(media_txd_o)
);

// File: tb/phy_lpbk_ctrl_tb.sv
// Directed bench for phy_lpbk_ctrl: one task per scenario, each checking
// its own results.
module phy_lpbk_ctrl_tb;

    localparam logic [4:0] A_CTRL = 5'd0;
    localparam logic [4:0] A_STAT = 5'd16;
    localparam logic [4:0] A_LBR  = 5'd23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        speed100 = 1'b1;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        tx_en = 1'b0;
    logic [3:0]  txd = '0;
    logic        lrx_dv = 1'b0;
    logic [3:0]  lrxd = '0;
    logic        rx_dv, mtx_en;
    logic [3:0]  rxd, mtxd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    phy_lpbk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .strap_fiber_i(strap), .speed100_i(speed100),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .tx_en_i(tx_en), .txd_i(txd), .line_rx_dv_i(lrx_dv), .line_rxd_i(lrxd),
        .rx_dv_o(rx_dv), .rxd_o(rxd), .media_tx_en_o(mtx_en), .media_txd_o(mtxd)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0; strap = s;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [15:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    // Drive one cycle of nibble inputs, then sample the registered outputs
    task automatic nib(input logic te, input logic [3:0] td, input logic ldv, input logic [3:0] ld,
                       input string req, input logic erdv, input logic [3:0] erd,
                       input logic emte, input logic [3:0] emtd);
        @(negedge clk);
        tx_en = te; txd = td; lrx_dv = ldv; lrxd = ld;
        @(negedge clk);
        check({req, " rx_dv"}, {15'd0, rx_dv}, {15'd0, erdv});
        check({req, " rxd"},   {12'd0, rxd},   {12'd0, erd});
        check({req, " media_en"},  {15'd0, mtx_en}, {15'd0, emte});
        check({req, " media_txd"}, {12'd0, mtxd},   {12'd0, emtd});
    endtask

    task automatic t_reset_defaults();
        do_reset(1'b1);
        rd_check("R1 fiber selector", A_LBR, 16'h0180);
        rd_check("R1 ctrl", A_CTRL, 16'h0000);
        rd_check("R1 status", A_STAT, 16'h0000);
        do_reset(1'b0);
        rd_check("R1 copper selector", A_LBR, 16'h0000);
    endtask

    task automatic t_lbr_rw();
        wr(A_LBR, 16'hFFFF);
        rd_check("R4 all fields set", A_LBR, 16'h03F0);
        wr(A_LBR, 16'h0140);
        rd_check("R4 pattern", A_LBR, 16'h0140);
    endtask

    task automatic t_ctrl_zero_clears();
        wr(A_LBR, 16'h02C0);
        rd_check("R4 selector 101 + digital", A_LBR, 16'h02C0);
        wr(A_CTRL, 16'h0000);
        rd_check("R3 write 0 clears", A_LBR, 16'h0000);
        rd_check("R2 ctrl stays 0", A_CTRL, 16'h0000);
    endtask

    task automatic t_ctrl_one();
        wr(A_LBR, 16'h03C0);
        wr(A_CTRL, 16'hFFFF);
        rd_check("R2 only bit 14", A_CTRL, 16'h4000);
        rd_check("R2 status bit 3", A_STAT, 16'h0008);
        rd_check("R3 R7 write 1 clears, analog read 1", A_LBR, 16'h0030);
    endtask

    task automatic t_lock();
        wr(A_LBR, 16'h03C0);
        rd_check("R8 locked fields", A_LBR, 16'h0030);
        wr(A_LBR, 16'h0010);
        rd_check("R7 analog forced", A_LBR, 16'h0030);
        wr(A_CTRL, 16'h0000);
        rd_check("R7 R8 stored analog after exit", A_LBR, 16'h0010);
        rd_check("R2 status cleared", A_STAT, 16'h0000);
        wr(A_LBR, 16'h0000);
    endtask

    task automatic t_lpbk_data();
        wr(A_CTRL, 16'h4000);
        speed100 = 1'b1;
        nib(1'b1, 4'hA, 1'b1, 4'h5, "R5 R6 100M", 1'b1, 4'hA, 1'b0, 4'h0);
        speed100 = 1'b0;
        nib(1'b1, 4'h3, 1'b1, 4'h5, "R5 R6 10M", 1'b1, 4'h3, 1'b0, 4'h0);
        nib(1'b0, 4'h9, 1'b1, 4'h5, "R5 idle", 1'b0, 4'h9, 1'b0, 4'h0);
        wr(A_CTRL, 16'h0000);
    endtask

    task automatic t_normal100();
        speed100 = 1'b1;
        nib(1'b1, 4'h9, 1'b1, 4'h6, "R10 tx", 1'b1, 4'h6, 1'b1, 4'h9);
        nib(1'b0, 4'h0, 1'b1, 4'hE, "R10 rx only", 1'b1, 4'hE, 1'b0, 4'h0);
    endtask

    task automatic t_normal10();
        speed100 = 1'b0;
        nib(1'b1, 4'hC, 1'b1, 4'h6, "R9 echo", 1'b1, 4'hC, 1'b1, 4'hC);
        nib(1'b0, 4'h0, 1'b1, 4'h7, "R9 line", 1'b1, 4'h7, 1'b0, 4'h0);
        speed100 = 1'b1;
    endtask

    task automatic t_ignored();
        wr(A_STAT, 16'hFFFF);
        wr(5'd5, 16'hFFFF);
        rd_check("R11 ctrl", A_CTRL, 16'h0000);
        rd_check("R11 status", A_STAT, 16'h0000);
        rd_check("R11 lbr", A_LBR, 16'h0000);
    endtask

    initial begin
        t_reset_defaults();
        t_lbr_rw();
        t_ctrl_zero_clears();
        t_ctrl_one();
        t_lock();
        t_lpbk_data();
        t_normal100();
        t_normal10();
        t_ignored();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule